// File: doc/BRIEF.md
# E1 System-Side Biframe Alignment Monitor

This block watches the time slot 0 byte of each frame arriving from the system side of an E1 transmit path. It is used when the spare international bits are taken from the system interface. The system must mark its frames with bit 2 of time slot 0. A frame with bit 2 at 1 carries the spare bit for a NOT-FAS line frame. The frame after it must have bit 2 at 0, and it carries the spare bit for a FAS line frame. The monitor uses this pairing to keep system data lined up with the line's FAS and NOT-FAS frames.

The monitor starts out of alignment and searches for the pattern. It declares alignment when a frame with bit 2 at 1 is followed directly by a frame with bit 2 at 0. From then on it tracks which line frame type each system frame feeds. Any frame that breaks the alternation takes the monitor back to the loss state and a new search begins. Loss and recovery each set a sticky flag, and a one-cycle clear strobe resets each flag. While alignment is lost, a corrupt-enable output tells the transmit path to spoil outgoing data, but only when the system interface is the selected source of the spare bits.

Bits of the time slot 0 byte are numbered 1 to 8, with bit 1 the most significant. Bit 2 is therefore `ts0_byte_i[6]`.

Top module: `e1_biframe_mon`

## Requirements
- R1: After reset `lost_o` is 1, and `loss_flag_o`, `regain_flag_o` and `fas_frame_o` are 0.
- R2: Only bit 2 of the byte (`ts0_byte_i[6]`) is examined, and only on cycles where `ts0_vld_i` is 1. The other seven bits have no effect on any output.
- R3: While lost, a strobed frame with bit 2 at 0 that directly follows a strobed frame with bit 2 at 1 declares alignment. `lost_o` falls at the clock edge that samples the 0 frame.
- R4: While lost, a 0 frame that is not directly preceded by a 1 frame leaves the monitor lost. After a run of several 1 frames, the last 1 still opens a valid pair.
- R5: On the edge that declares alignment, `fas_frame_o` becomes 1, because the 0 frame feeds a FAS frame. While aligned, `fas_frame_o` toggles on every strobed frame.
- R6: While aligned, the bit 2 expected on the next frame equals `fas_frame_o`. A frame with any other value makes `lost_o` rise and `fas_frame_o` fall at that edge. The breaking frame does not count toward the new search.
- R7: `loss_flag_o` is set on each change from aligned to lost and stays set until `clr_loss_i` is 1 on a clock edge. If the set and the clear arrive on the same edge, the set wins.
- R8: `regain_flag_o` is set on each change from lost to aligned and stays set until `clr_regain_i` is 1 on a clock edge. If the set and the clear arrive on the same edge, the set wins.
- R9: `corrupt_o` is 1 exactly when `lost_o` is 1 and `sys_si_src_i` is 1. It follows `sys_si_src_i` with no clock delay.
- R10: `lost_o` and `fas_frame_o` change only on clock edges where `ts0_vld_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ts0_vld_i | input | 1 | One-cycle strobe per frame: time slot 0 byte valid |
| ts0_byte_i | input | 8 | Time slot 0 byte from the system side; bit 2 is index 6 |
| sys_si_src_i | input | 1 | 1 when the system interface sources the spare bits |
| clr_loss_i | input | 1 | Write-one-to-clear strobe for the loss flag |
| clr_regain_i | input | 1 | Write-one-to-clear strobe for the regain flag |
| lost_o | output | 1 | Biframe alignment lost, search in progress |
| loss_flag_o | output | 1 | Sticky: alignment was lost |
| regain_flag_o | output | 1 | Sticky: alignment was found |
| fas_frame_o | output | 1 | Last strobed frame feeds a FAS line frame (0 while lost) |
| corrupt_o | output | 1 | Corrupt-enable for the transmit path |

## Verification
`lost_o`, `fas_frame_o` and both sticky flags are registered. Each one is due on the first rising edge that samples the strobe or clear that causes it. `corrupt_o` follows `sys_si_src_i` within the same cycle. The bench drives every input on a falling edge, holds it across one rising edge, and reads the outputs on the next falling edge. A change of the source select is read a short delay after it is driven, with no clock in between.

// File: rtl/e1_bfa_pkg.sv
package e1_bfa_pkg;
  typedef enum logic {ST_LOST = 1'b0, ST_LOCK = 1'b1} bfa_state_e;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned BIT2_IDX = 6;  // bit 2 counted from MSB as bit 1
endpackage

// File: rtl/bfa_bit_tap.sv
module bfa_bit_tap #(
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned BIT_IDX = 6
) (
  input  logic              vld_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              step_o,
  output logic              bit_o
);
  assign step_o = vld_i;
  assign bit_o  = byte_i[BIT_IDX];
endmodule

// File: rtl/bfa_search.sv
module bfa_search #(
  parameter int unsigned PAIRS = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  input  logic step_i,
  input  logic bit_i,
  output logic found_o
);
  localparam int unsigned RUN = 2 * PAIRS;
  localparam int unsigned CW  = $clog2(RUN + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          want_zero;

  assign want_zero = cnt_q[0];

  always_comb begin
    cnt_d   = cnt_q;
    found_o = 1'b0;
    if (hold_i) begin
      cnt_d = '0;
    end else if (step_i) begin
      if (!want_zero) begin
        cnt_d = bit_i ? cnt_q + CW'(1) : '0;
      end else if (!bit_i) begin
        if (cnt_q + CW'(1) == CW'(RUN)) begin
          found_o = 1'b1;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end else begin
        cnt_d = CW'(1);  // a repeated 1 may open a fresh pair
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end
endmodule

// File: rtl/bfa_track.sv
module bfa_track
  import e1_bfa_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  input  logic bit_i,
  input  logic found_i,
  output logic lost_o,
  output logic fas_o,
  output logic loss_ev_o,
  output logic regain_ev_o
);
  bfa_state_e state_q;
  logic       fas_q;

  // after a FAS-feeding frame the next must carry bit 2 = 1, and vice versa
  assign loss_ev_o   = step_i && (state_q == ST_LOCK) && (bit_i != fas_q);
  assign regain_ev_o = (state_q == ST_LOST) && found_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_LOST;
      fas_q   <= 1'b0;
    end else if (loss_ev_o) begin
      state_q <= ST_LOST;
      fas_q   <= 1'b0;
    end else if (regain_ev_o) begin
      state_q <= ST_LOCK;
      fas_q   <= 1'b1;
    end else if (step_i && state_q == ST_LOCK) begin
      fas_q   <= ~fas_q;
    end
  end

  assign lost_o = (state_q == ST_LOST);
  assign fas_o  = fas_q;
endmodule

// File: rtl/bfa_sticky.sv
module bfa_sticky (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/e1_biframe_mon.sv
module e1_biframe_mon #(
  parameter int unsigned BYTE_W        = e1_bfa_pkg::BYTE_W,
  parameter int unsigned BIT_IDX       = e1_bfa_pkg::BIT2_IDX,
  parameter int unsigned CONFIRM_PAIRS = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ts0_vld_i,
  input  logic [BYTE_W-1:0] ts0_byte_i,
  input  logic              sys_si_src_i,
  input  logic              clr_loss_i,
  input  logic              clr_regain_i,
  output logic              lost_o,
  output logic              loss_flag_o,
  output logic              regain_flag_o,
  output logic              fas_frame_o,
  output logic              corrupt_o
);
  logic step, bit2, found, lost, loss_ev, regain_ev;

  bfa_bit_tap #(.BYTE_W(BYTE_W), .BIT_IDX(BIT_IDX)) u_tap (
    .vld_i(ts0_vld_i), .byte_i(ts0_byte_i), .step_o(step), .bit_o(bit2)
  );

  bfa_search #(.PAIRS(CONFIRM_PAIRS)) u_search (
    .clk_i(clk_i), .rst_ni(rst_ni), .hold_i(!lost), .step_i(step),
    .bit_i(bit2), .found_o(found)
  );

  bfa_track u_track (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(step), .bit_i(bit2),
    .found_i(found), .lost_o(lost), .fas_o(fas_frame_o),
    .loss_ev_o(loss_ev), .regain_ev_o(regain_ev)
  );

  bfa_sticky u_loss_flag (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(loss_ev), .clr_i(clr_loss_i),
    .flag_o(loss_flag_o)
  );

  bfa_sticky u_regain_flag (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(regain_ev), .clr_i(clr_regain_i),
    .flag_o(regain_flag_o)
  );

  assign lost_o    = lost;
  assign corrupt_o = lost && sys_si_src_i;
endmodule

// File: rtl/e1_bfa_mon_chk.sv
module e1_bfa_mon_chk #(
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned BIT_IDX = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ts0_vld_i,
  input logic [BYTE_W-1:0] ts0_byte_i,
  input logic              sys_si_src_i,
  input logic              clr_loss_i,
  input logic              clr_regain_i,
  input logic              lost_o,
  input logic              loss_flag_o,
  input logic              regain_flag_o,
  input logic              fas_frame_o,
  input logic              corrupt_o
);
  assert_no_corrupt_unselected_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sys_si_src_i |-> !corrupt_o);
  assert_no_corrupt_aligned_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lost_o |-> !corrupt_o);
  assert_hold_no_strobe_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ts0_vld_i |=> ($stable(lost_o) && $stable(fas_frame_o)));
  assert_break_loses_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lost_o && ts0_vld_i && (ts0_byte_i[BIT_IDX] != fas_frame_o)) |=> (lost_o && !fas_frame_o));
  assert_zero_feeds_fas_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lost_o && ts0_vld_i && !ts0_byte_i[BIT_IDX] && !fas_frame_o) |=> (!lost_o && fas_frame_o));
  assert_lost_no_phase_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lost_o |-> !fas_frame_o);
  assert_loss_flag_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lost_o) |-> loss_flag_o);
  assert_loss_flag_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loss_flag_o && !clr_loss_i) |=> loss_flag_o);
  assert_regain_flag_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lost_o) |-> regain_flag_o);
  assert_regain_flag_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (regain_flag_o && !clr_regain_i) |=> regain_flag_o);
  assert_lock_needs_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lost_o && !(ts0_vld_i && !ts0_byte_i[BIT_IDX])) |=> lost_o);
endmodule

bind e1_biframe_mon e1_bfa_mon_chk #(.BYTE_W(BYTE_W), .BIT_IDX(BIT_IDX)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ts0_vld_i(ts0_vld_i), .ts0_byte_i(ts0_byte_i),
  .sys_si_src_i(sys_si_src_i), .clr_loss_i(clr_loss_i), .clr_regain_i(clr_regain_i),
  .lost_o(lost_o), .loss_flag_o(loss_flag_o), .regain_flag_o(regain_flag_o),
  .fas_frame_o(fas_frame_o), .corrupt_o(corrupt_o)
);

// File: tb/e1_biframe_mon_bench.sv
module e1_biframe_mon_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       vld = 1'b0;
  logic [7:0] byte_in = 8'h00;
  logic       src = 1'b1;
  logic       clr_loss = 1'b0;
  logic       clr_regain = 1'b0;
  logic       lost, loss_flag, regain_flag, fas_frame, corrupt;
  int         checks = 0;
  int         errors = 0;

  always #2ns clk = ~clk;

  e1_biframe_mon u_e1_biframe_mon (
    .clk_i(clk), .rst_ni(rst_n), .ts0_vld_i(vld), .ts0_byte_i(byte_in),
    .sys_si_src_i(src), .clr_loss_i(clr_loss), .clr_regain_i(clr_regain),
    .lost_o(lost), .loss_flag_o(loss_flag), .regain_flag_o(regain_flag),
    .fas_frame_o(fas_frame), .corrupt_o(corrupt)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // one strobed frame; outputs read at the falling edge after the sampling edge
  task automatic frame(input logic b2, input logic [7:0] rest,
                       input logic cl = 1'b0, input logic cr = 1'b0);
    @(negedge clk);
    vld        = 1'b1;
    byte_in    = {rest[7], b2, rest[5:0]};
    clr_loss   = cl;
    clr_regain = cr;
    @(negedge clk);
    vld        = 1'b0;
    clr_loss   = 1'b0;
    clr_regain = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 lost", lost, 1'b1);
    check("R1 loss_flag", loss_flag, 1'b0);
    check("R1 regain_flag", regain_flag, 1'b0);
    check("R1 fas_frame", fas_frame, 1'b0);
    check("R9 corrupt in reset loss", corrupt, 1'b1);
  endtask

  task automatic t_acquire;
    frame(1'b1, 8'h00);
    check("R3 lost after lone 1", lost, 1'b1);
    frame(1'b0, 8'hBF);
    check("R3 aligned after 1,0", lost, 1'b0);
    check("R8 regain_flag set", regain_flag, 1'b1);
    check("R5 fas_frame on lock", fas_frame, 1'b1);
    check("R9 corrupt when aligned", corrupt, 1'b0);
    check("R7 loss_flag untouched", loss_flag, 1'b0);
  endtask

  task automatic t_track;
    frame(1'b1, 8'h15);
    check("R5 toggle to not-fas", fas_frame, 1'b0);
    check("R2 aligned with noise bits", lost, 1'b0);
    frame(1'b0, 8'hA2);
    check("R5 toggle to fas", fas_frame, 1'b1);
    frame(1'b1, 8'h3C);
    check("R5 toggle again", fas_frame, 1'b0);
    frame(1'b0, 8'hFF);
    check("R5 fas again", fas_frame, 1'b1);
    check("R2 still aligned", lost, 1'b0);
  endtask

  task automatic t_no_strobe;
    // wrong bit 2 on non-strobed cycles must be ignored
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      byte_in = (i % 2 == 0) ? 8'h00 : 8'hBF;
    end
    @(negedge clk);
    check("R10 lost held without strobe", lost, 1'b0);
    check("R10 fas held without strobe", fas_frame, 1'b1);
    check("R2 no effect without strobe", loss_flag, 1'b0);
  endtask

  task automatic t_clr_regain;
    @(negedge clk);
    clr_regain = 1'b1;
    @(negedge clk);
    clr_regain = 1'b0;
    check("R8 regain_flag cleared", regain_flag, 1'b0);
    check("R7 loss_flag not cleared by other strobe", loss_flag, 1'b0);
  endtask

  task automatic t_break_zero;
    frame(1'b0, 8'h00);  // expected 1 after fas frame
    check("R6 lost on zero break", lost, 1'b1);
    check("R6 fas cleared", fas_frame, 1'b0);
    check("R7 loss_flag set", loss_flag, 1'b1);
    check("R9 corrupt while lost", corrupt, 1'b1);
  endtask

  task automatic t_src;
    @(negedge clk);
    src = 1'b0;
    #1ns;
    check("R9 corrupt off when not source", corrupt, 1'b0);
    src = 1'b1;
    #1ns;
    check("R9 corrupt back on", corrupt, 1'b1);
  endtask

  task automatic t_search_false;
    frame(1'b0, 8'h00);
    check("R4 lone 0 no lock", lost, 1'b1);
    frame(1'b0, 8'hFF);
    check("R4 second 0 no lock", lost, 1'b1);
    frame(1'b1, 8'h00);
    check("R4 1 no lock", lost, 1'b1);
    frame(1'b1, 8'hFF);
    check("R4 repeated 1 no lock", lost, 1'b1);
    frame(1'b0, 8'h81);
    check("R4 lock after 1,1,0", lost, 1'b0);
    check("R5 fas after search lock", fas_frame, 1'b1);
    check("R8 regain set again", regain_flag, 1'b1);
  endtask

  task automatic t_break_one;
    frame(1'b1, 8'h00);
    check("R5 not-fas frame", fas_frame, 1'b0);
    frame(1'b1, 8'h00);  // expected 0
    check("R6 lost on one break", lost, 1'b1);
    frame(1'b0, 8'h00);
    check("R6 breaking frame not counted", lost, 1'b1);
    frame(1'b1, 8'h00);
    frame(1'b0, 8'h00);
    check("R3 relock", lost, 1'b0);
  endtask

  task automatic t_w1c;
    @(negedge clk);
    clr_loss = 1'b1;
    @(negedge clk);
    clr_loss = 1'b0;
    check("R7 loss_flag cleared", loss_flag, 1'b0);
    check("R8 regain_flag kept", regain_flag, 1'b1);
    frame(1'b0, 8'h00, 1'b1, 1'b0);  // break with concurrent clear
    check("R7 set wins over clear", loss_flag, 1'b1);
    check("R6 lost", lost, 1'b1);
    frame(1'b1, 8'h00);
    frame(1'b0, 8'h00, 1'b0, 1'b1);  // lock with concurrent clear
    check("R8 set wins over clear", regain_flag, 1'b1);
    check("R3 aligned", lost, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_acquire();
    t_track();
    t_no_strobe();
    t_clr_regain();
    t_break_zero();
    t_src();
    t_search_false();
    t_break_one();
    t_w1c();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule